// File: doc/BRIEF.md
# Ten-Bit Sample Byte-Pair Codec

This block carries 10-bit samples across a byte link that can only pass byte values below 128. The transmit half takes a sample presented as a high byte, which holds the two upper sample bits, and a low byte. It moves the top bit of the low byte into the high byte so that neither transmitted byte has bit 7 set. It then sends the two bytes, low byte first, on a valid/ready byte stream. On request it sends an end-of-stream marker in place of a sample.

The receive half takes byte pairs from the link. A static control input tells it that the link inverts the data; each byte is then corrected before use. It rebuilds the 10-bit sample and reports it with a one-cycle valid pulse. It reports the end marker with its own pulse, and it reports a malformed high byte as an error. The two halves are independent, so a single instance can serve both ends of a loopback or one side each of two links.

Top module: `sample_pair_codec`

## Requirements
- R1: After reset `enc_in_ready` is 1, `enc_out_valid` is 0 and `dec_out_valid`, `dec_out_end` and `dec_out_err` are 0.
- R2: For an accepted sample the first transmitted byte is `{0, lo[6:0]}` and the second is `{00000, hi[1:0], lo[7]}`. Every transmitted byte is below 128. For example, hi 0x03 with lo 0xFF gives 0x7F then 0x07.
- R3: The low-derived byte is sent first and the high-derived byte second. While `enc_out_valid` is 1 and `enc_out_ready` is 0, the byte and the valid stay unchanged.
- R4: `enc_in_ready` is 0 from the cycle after a sample is accepted until the second byte has been taken. It is 1 again in the cycle after that.
- R5: A sample accepted with `enc_in_mark` = 1 sends 0x7F twice, and its hi and lo inputs have no effect.
- R6: Bits 7..2 of `enc_in_hi` have no effect on the transmitted bytes.
- R7: The decoder treats the first received byte as low and the second as high. One cycle after the second byte it pulses `dec_out_valid` with `dec_out_sample = {high[2:0], low[6:0]}`. Bit 7 of the low byte is ignored.
- R8: When `dec_invert` is 1, each received byte b is replaced by 255 − b before any decoding.
- R9: A pair whose corrected bytes are both 127 pulses `dec_out_end` and does not pulse `dec_out_valid`.
- R10: A pair whose corrected high byte exceeds 7 and which is not the end marker pulses `dec_out_err` and does not pulse `dec_out_valid`.
- R11: At most one of the three decoder result outputs is high in any cycle, and each result lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Sample or marker request offered |
| enc_in_ready | output | 1 | Encoder can accept a request |
| enc_in_hi | input | 8 | Sample high byte (bits 1..0 used) |
| enc_in_lo | input | 8 | Sample low byte |
| enc_in_mark | input | 1 | Send end marker instead of sample |
| enc_out_valid | output | 1 | Transmit byte available |
| enc_out_ready | input | 1 | Link takes the byte |
| enc_out_byte | output | 8 | Transmit byte |
| dec_invert | input | 1 | Link inverts bytes |
| dec_in_valid | input | 1 | Received byte strobe |
| dec_in_byte | input | 8 | Received byte |
| dec_out_valid | output | 1 | Rebuilt sample pulse |
| dec_out_sample | output | 10 | Rebuilt sample |
| dec_out_end | output | 1 | End marker pulse |
| dec_out_err | output | 1 | Malformed pair pulse |

## Verification
Several properties are checked on every cycle: transmitted bytes never carry bit 7, a stalled byte holds still, the encoder refuses new work while a pair is in flight, and decoder results are exclusive single-cycle pulses that follow a received byte. Whether the bytes carry the right bit regrouping, whether inputs are ignored as required, and whether inversion, marker and error decoding give the right values can only be shown by the bench's scenarios. These scenarios compare each output against values computed from the requirements, both with a link that takes every byte and with one that stalls.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [1:0] {
    ENC_IDLE = 2'd0,
    ENC_LO   = 2'd1,
    ENC_HI   = 2'd2
  } enc_state_e;
endpackage

// File: rtl/spc_encoder.sv
module spc_encoder
  import spc_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_hi,
  input  logic [BYTE_W-1:0] in_lo,
  input  logic              in_mark,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);
  localparam int HI_ORIG = SAMPLE_W - BYTE_W;
  localparam int PAD_W   = BYTE_W - HI_ORIG - 1;
  localparam logic [BYTE_W-1:0] MARK = {1'b0, {(BYTE_W-1){1'b1}}};

  enc_state_e        state_q;
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] lo_enc, hi_enc, first_b, second_b;
  logic              unused_hi;

  assign unused_hi = ^in_hi[BYTE_W-1:HI_ORIG];
  assign lo_enc    = {1'b0, in_lo[BYTE_W-2:0]};
  assign hi_enc    = {{PAD_W{1'b0}}, in_hi[HI_ORIG-1:0], in_lo[BYTE_W-1]};
  assign first_b   = in_mark ? MARK : lo_enc;
  assign second_b  = in_mark ? MARK : hi_enc;

  assign in_ready  = (state_q == ENC_IDLE);
  assign out_valid = (state_q != ENC_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ENC_IDLE;
      hold_q   <= '0;
      out_byte <= '0;
    end else begin
      unique case (state_q)
        ENC_IDLE: if (in_valid) begin
          out_byte <= first_b;
          hold_q   <= second_b;
          state_q  <= ENC_LO;
        end
        ENC_LO: if (out_ready) begin
          out_byte <= hold_q;
          state_q  <= ENC_HI;
        end
        ENC_HI: if (out_ready) begin
          state_q  <= ENC_IDLE;
        end
        default: state_q <= ENC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spc_byte_fix.sv
module spc_byte_fix #(
  parameter int BYTE_W      = 8,
  parameter bit LINK_INV_EN = 1'b1
) (
  input  logic              invert,
  input  logic [BYTE_W-1:0] raw,
  output logic [BYTE_W-1:0] fixed
);
  generate
    if (LINK_INV_EN) begin : g_inv
      // all-ones minus b equals bitwise complement
      assign fixed = invert ? ~raw : raw;
    end else begin : g_pass
      logic unused_inv;
      assign unused_inv = invert;
      assign fixed = raw;
    end
  endgenerate
endmodule

// File: rtl/spc_decoder.sv
module spc_decoder #(
  parameter int BYTE_W   = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_byte,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_end,
  output logic                out_err
);
  localparam int HI_PAY = SAMPLE_W - (BYTE_W - 1);
  localparam logic [BYTE_W-1:0] MARK = {1'b0, {(BYTE_W-1){1'b1}}};

  logic              phase_q;
  logic [BYTE_W-1:0] lo_q;
  logic              is_mark, hi_over, unused_lo;

  assign unused_lo = lo_q[BYTE_W-1];
  assign is_mark   = (lo_q == MARK) && (in_byte == MARK);
  assign hi_over   = |in_byte[BYTE_W-1:HI_PAY];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= 1'b0;
      lo_q       <= '0;
      out_valid  <= 1'b0;
      out_end    <= 1'b0;
      out_err    <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= 1'b0;
      out_end   <= 1'b0;
      out_err   <= 1'b0;
      if (in_valid) begin
        if (!phase_q) begin
          lo_q    <= in_byte;
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          if (is_mark) begin
            out_end <= 1'b1;
          end else if (hi_over) begin
            out_err <= 1'b1;
          end else begin
            out_valid  <= 1'b1;
            out_sample <= {in_byte[HI_PAY-1:0], lo_q[BYTE_W-2:0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sample_pair_codec.sv
module sample_pair_codec #(
  parameter int BYTE_W      = 8,
  parameter int SAMPLE_W    = 10,
  parameter bit LINK_INV_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enc_in_valid,
  output logic                enc_in_ready,
  input  logic [BYTE_W-1:0]   enc_in_hi,
  input  logic [BYTE_W-1:0]   enc_in_lo,
  input  logic                enc_in_mark,
  output logic                enc_out_valid,
  input  logic                enc_out_ready,
  output logic [BYTE_W-1:0]   enc_out_byte,
  input  logic                dec_invert,
  input  logic                dec_in_valid,
  input  logic [BYTE_W-1:0]   dec_in_byte,
  output logic                dec_out_valid,
  output logic [SAMPLE_W-1:0] dec_out_sample,
  output logic                dec_out_end,
  output logic                dec_out_err
);
  logic [BYTE_W-1:0] rx_fixed;

  spc_encoder #(.BYTE_W(BYTE_W), .SAMPLE_W(SAMPLE_W)) enc_i (
    .clk(clk), .rst(rst),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready),
    .in_hi(enc_in_hi), .in_lo(enc_in_lo), .in_mark(enc_in_mark),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready),
    .out_byte(enc_out_byte)
  );

  spc_byte_fix #(.BYTE_W(BYTE_W), .LINK_INV_EN(LINK_INV_EN)) fix_i (
    .invert(dec_invert), .raw(dec_in_byte), .fixed(rx_fixed)
  );

  spc_decoder #(.BYTE_W(BYTE_W), .SAMPLE_W(SAMPLE_W)) dec_i (
    .clk(clk), .rst(rst),
    .in_valid(dec_in_valid), .in_byte(rx_fixed),
    .out_valid(dec_out_valid), .out_sample(dec_out_sample),
    .out_end(dec_out_end), .out_err(dec_out_err)
  );
endmodule

// File: rtl/sample_pair_codec_chk.sv
module sample_pair_codec_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              enc_in_ready,
  input logic              enc_out_valid,
  input logic              enc_out_ready,
  input logic [BYTE_W-1:0] enc_out_byte,
  input logic              dec_in_valid,
  input logic              dec_out_valid,
  input logic              dec_out_end,
  input logic              dec_out_err
);
  logic any_res;
  assign any_res = dec_out_valid | dec_out_end | dec_out_err;

  a_r2_byte_below_half: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid |-> !enc_out_byte[BYTE_W-1]);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (enc_out_valid && !enc_out_ready) |=> (enc_out_valid && $stable(enc_out_byte)));

  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid |-> !enc_in_ready);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_out_valid, dec_out_end, dec_out_err}));

  a_r11_single_cycle: assert property (@(posedge clk) disable iff (rst)
    any_res |=> !any_res);

  a_r7_follows_byte: assert property (@(posedge clk) disable iff (rst)
    any_res |-> $past(dec_in_valid));
endmodule

bind sample_pair_codec sample_pair_codec_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst(rst),
  .enc_in_ready(enc_in_ready), .enc_out_valid(enc_out_valid),
  .enc_out_ready(enc_out_ready), .enc_out_byte(enc_out_byte),
  .dec_in_valid(dec_in_valid), .dec_out_valid(dec_out_valid),
  .dec_out_end(dec_out_end), .dec_out_err(dec_out_err)
);

// File: tb/sample_pair_codec_tb_top.sv
module sample_pair_codec_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_in_valid = 1'b0, enc_in_mark = 1'b0;
  logic [7:0] enc_in_hi = '0, enc_in_lo = '0;
  logic       enc_in_ready, enc_out_valid;
  logic       enc_out_ready = 1'b1;
  logic [7:0] enc_out_byte;
  logic       dec_invert = 1'b0, dec_in_valid = 1'b0;
  logic [7:0] dec_in_byte = '0;
  logic       dec_out_valid, dec_out_end, dec_out_err;
  logic [9:0] dec_out_sample;

  int   n_chk = 0, n_bad = 0;
  bit   stall_en = 1'b0, done = 1'b0;
  int   cyc = 0;
  logic [7:0]  enc_q[$];
  logic [11:0] dec_q[$];

  always #10 clk = ~clk;

  sample_pair_codec dut_i (
    .clk(clk), .rst(rst),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
    .enc_in_hi(enc_in_hi), .enc_in_lo(enc_in_lo), .enc_in_mark(enc_in_mark),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
    .enc_out_byte(enc_out_byte),
    .dec_invert(dec_invert), .dec_in_valid(dec_in_valid), .dec_in_byte(dec_in_byte),
    .dec_out_valid(dec_out_valid), .dec_out_sample(dec_out_sample),
    .dec_out_end(dec_out_end), .dec_out_err(dec_out_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // link-side ready pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 enc_out_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // encoder driver: pushes the expected byte pair, then offers the request
  task automatic send(input logic [7:0] hi, input logic [7:0] lo, input bit mark);
    if (mark) begin
      enc_q.push_back(8'h7F); enc_q.push_back(8'h7F);
    end else begin
      enc_q.push_back({1'b0, lo[6:0]});
      enc_q.push_back({5'b0, hi[1:0], lo[7]});
    end
    @(posedge clk); #2;
    enc_in_valid = 1'b1; enc_in_hi = hi; enc_in_lo = lo; enc_in_mark = mark;
    forever begin
      @(negedge clk);
      if (enc_in_ready) break;
    end
    @(posedge clk); #2;
    enc_in_valid = 1'b0;
    @(negedge clk);
    check(!enc_in_ready && enc_out_valid, "R4 busy after accept", enc_in_ready, 0);
  endtask

  function automatic logic [11:0] dec_exp(input logic [7:0] b0, input logic [7:0] b1,
                                          input bit inv);
    logic [7:0] lo, hi;
    lo = inv ? 8'd255 - b0 : b0;
    hi = inv ? 8'd255 - b1 : b1;
    if (lo == 8'd127 && hi == 8'd127) return {2'd2, 10'd0};
    if (hi > 8'd7) return {2'd3, 10'd0};
    return {2'd1, hi[2:0], lo[6:0]};
  endfunction

  task automatic rx_pair(input logic [7:0] b0, input logic [7:0] b1);
    dec_q.push_back(dec_exp(b0, b1, dec_invert));
    @(posedge clk); #2;
    dec_in_valid = 1'b1; dec_in_byte = b0;
    @(posedge clk); #2;
    dec_in_byte = b1;
    @(posedge clk); #2;
    dec_in_valid = 1'b0;
  endtask

  // encoder monitor
  logic [7:0] held_b;
  bit         held = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) begin
        check(enc_out_valid && enc_out_byte == held_b, "R3 stall hold", enc_out_byte, held_b);
        held = 1'b0;
      end
      if (enc_out_valid && !enc_out_ready) begin
        held = 1'b1; held_b = enc_out_byte;
      end
      if (enc_out_valid && enc_out_ready) begin
        if (enc_q.size() == 0) check(1'b0, "R2 R3 unexpected byte", enc_out_byte, 0);
        else begin
          logic [7:0] e;
          e = enc_q.pop_front();
          check(enc_out_byte == e, "R2 R3 R5 R6 tx byte", enc_out_byte, e);
        end
      end
    end
  end

  // decoder monitor
  always @(negedge clk) begin
    if (!rst && (dec_out_valid || dec_out_end || dec_out_err)) begin
      logic [11:0] act;
      act = {dec_out_err ? 2'd3 : dec_out_end ? 2'd2 : 2'd1,
             dec_out_valid ? dec_out_sample : 10'd0};
      if (dec_q.size() == 0) check(1'b0, "R7 unexpected result", act, 0);
      else begin
        logic [11:0] e;
        e = dec_q.pop_front();
        check(act == e && $countones({dec_out_valid, dec_out_end, dec_out_err}) == 1,
              "R7 R8 R9 R10 R11 rx result", act, e);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(enc_in_ready && !enc_out_valid && !dec_out_valid && !dec_out_end && !dec_out_err,
          "R1 reset state", {enc_in_ready, enc_out_valid, dec_out_valid, dec_out_end, dec_out_err},
          5'b10000);

    // encoder, link always ready
    send(8'h03, 8'hFF, 1'b0);   // R2 example 7F,07
    send(8'h00, 8'h00, 1'b0);
    send(8'h01, 8'h80, 1'b0);
    send(8'h02, 8'h7F, 1'b0);
    send(8'hFC, 8'h81, 1'b0);   // R6 upper bits ignored
    send(8'h03, 8'hFF, 1'b1);   // R5 marker
    // encoder, stalling link
    stall_en = 1'b1;
    for (int i = 0; i < 12; i++) send(8'(i * 37), 8'(i * 53 + 11), (i % 5) == 4);
    stall_en = 1'b0;

    // decoder, plain link
    rx_pair(8'h7F, 8'h07);      // R7 -> 0x3FF
    rx_pair(8'h00, 8'h00);
    rx_pair(8'hFF, 8'h02);      // low bit 7 ignored
    rx_pair(8'h7F, 8'h7F);      // R9
    rx_pair(8'h05, 8'h08);      // R10
    rx_pair(8'h7F, 8'h80);      // R10
    rx_pair(8'h80, 8'h80);      // R10 not a marker uninverted
    for (int i = 0; i < 16; i++) rx_pair(8'({i[6:0]} * 9), 8'(i % 8));
    // decoder, inverted link (R8)
    @(posedge clk); #2 dec_invert = 1'b1;
    rx_pair(8'h80, 8'hF8);      // -> 0x3FF
    rx_pair(8'h80, 8'h80);      // R9 marker after inversion
    rx_pair(8'hFF, 8'hFF);      // -> 0
    rx_pair(8'hF0, 8'h00);      // R10 high 255
    for (int i = 0; i < 8; i++) rx_pair(8'(255 - i * 13), 8'(255 - i));
    @(posedge clk); #2 dec_invert = 1'b0;

    repeat (10) @(posedge clk);
    @(negedge clk);
    check(enc_q.size() == 0, "R3 all tx bytes seen", enc_q.size(), 0);
    check(dec_q.size() == 0, "R7 all rx results seen", dec_q.size(), 0);
    check(enc_in_ready && !enc_out_valid, "R4 idle at end", enc_in_ready, 1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule